// File: doc/BRIEF.md
# Strided Vector Load/Store Unit for Interleaved Banked Memory

This unit runs one vector memory operation at a time. From a base word address, a stride and an element count it forms one address per element. Each access goes over a single shared request port to a memory made of word-interleaved banks, and each bank stays occupied for a fixed number of cycles after it accepts a request. Per-bank down-counters record which banks are occupied. Issue holds only when the next element maps to a bank whose counter has not reached zero, so sequences that spread across the banks reach one element per cycle.

A load collects the returned words from the single shared return port and writes them into a vector register. Each word goes to the element index recorded when its request was issued. A store reads the vector register in element order and sends each element with its request. The latency is fixed, so a tag pipeline as deep as that latency lines every return up with its tag.

The controller has three states. IDLE waits for a start. ISSUE steps through the elements. DRAIN waits for the last bank access to complete. The transitions are:
- *launch* (IDLE→ISSUE): start with a nonzero count.
- *empty-op* (IDLE→IDLE): start with a zero count; done pulses.
- *last-issued* (ISSUE→DRAIN): the final element is accepted.
- *stall* (ISSUE→ISSUE): the target bank is still occupied.
- *complete* (DRAIN→IDLE): the final access completes; done pulses.

Top module: `vec_stride_lsu`

## Requirements
- R1: Element k uses word address base + k·stride, modulo 2^ADDR_W. The stride is a two's-complement value.
- R2: The bank of an address is its low log2(NBANK) bits (the low 4 bits with 16 banks). Consecutive word addresses therefore fall in consecutive banks.
- R3: A bank never receives a new request within BANK_LAT (11) cycles of its previous request. At most one request is issued per cycle.
- R4: When successive elements touch distinct banks within any window of BANK_LAT elements (for example stride 1 or −1), one element issues per cycle. For a count N, done is seen N+BANK_LAT cycles after the edge that samples start.
- R5: A stride that is a multiple of NBANK issues one element every BANK_LAT cycles. Done is seen N·BANK_LAT+1 cycles after the start edge. Other strides that revisit a bank issue at the earliest cycle the bank is free; for stride 2 with N=16 that gives done at 30 cycles.
- R6: For a load, each returned word is written to the vector register with the element index recorded at issue. Writes occur in index order 0..N−1, and each write happens in the cycle the memory presents the word (BANK_LAT cycles after the request).
- R7: For a store, each request has mem_we_o=1. Its write data is the vector register word at vr_ridx_o, which equals the element index during the request cycle. A store makes no vector register writes.
- R8: done_o is a one-cycle pulse that follows the completion of the last bank access. busy_o is high from the cycle after start is sampled until done_o.
- R9: A start asserted while busy_o is high is ignored. The running operation keeps its parameters, its timing and its kind.
- R10: A start with count 0 issues no request and raises done_o in the cycle right after the start edge.
- R11: After reset, busy_o, done_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (sampled in IDLE only) |
| store_i | input | 1 | 1 = store, 0 = load |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Two's-complement element spacing in words |
| vlen_i | input | LEN_W | Element count, 0..VLEN_MAX |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Request on the shared memory port |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request word address |
| mem_wdata_o | output | DATA_W | Store data |
| mem_rvalid_i | input | 1 | Load data present on the shared return port |
| mem_rdata_i | input | DATA_W | Load data |
| vr_ridx_o | output | IDX_W | Vector register read index for stores |
| vr_rdata_i | input | DATA_W | Vector register read data (combinational) |
| vr_we_o | output | 1 | Vector register write enable |
| vr_widx_o | output | IDX_W | Vector register write index |
| vr_wdata_o | output | DATA_W | Vector register write data |

## Verification
The embedded properties guard the following on every cycle:
- the address advancing by exactly the latched stride;
- no request reaching a bank whose counter is nonzero;
- returns arriving exactly when a load tag reaches the end of the tag pipeline, with indices ascending;
- the absence of register writes during stores;
- done lasting a single cycle.

Only the directed scenarios can show the end-to-end timing: one element per cycle for spread strides, one per eleven for same-bank strides, and the mixed stall pattern of stride 2. They also show the data landing at the right register index or memory word, the zero-count shortcut, and that a start during an operation changes nothing.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } lsu_state_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [LEN_W-1:0]  vlen_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  vlen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
            idx_q    <= '0;
            vlen_q   <= '0;
        end else if (load_i) begin
            addr_q   <= base_i;
            stride_q <= stride_i;
            idx_q    <= '0;
            vlen_q   <= vlen_i;
        end else if (step_i) begin
            addr_q   <= addr_q + stride_q;
            idx_q    <= idx_q + LEN_W'(1);
        end
    end

    assign addr_o = addr_q;
    assign idx_o  = idx_q[IDX_W-1:0];
    assign last_o = (idx_q == vlen_q - LEN_W'(1));

    // R1: every accepted element moves the address by the latched stride
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_q == $past(addr_q) + $past(stride_q)));

endmodule

// File: rtl/lsu_bank_busy.sv
module lsu_bank_busy #(
    parameter int NBANK = 16,
    parameter int LAT   = 11,
    localparam int BANK_W = $clog2(NBANK),
    localparam int CNT_W  = $clog2(LAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              free_o
);

    logic [CNT_W-1:0] cnt_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[b] <= '0;
            end else if (issue_i && bank_i == BANK_W'(b)) begin
                cnt_q[b] <= CNT_W'(LAT - 1);
            end else if (cnt_q[b] != '0) begin
                cnt_q[b] <= cnt_q[b] - CNT_W'(1);
            end
        end

        // R3: an occupied bank is never handed a new request
        p_bank_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[b] != '0) |-> !(issue_i && bank_i == BANK_W'(b)));
    end

    assign free_o = (cnt_q[bank_i] == '0);

endmodule

// File: rtl/lsu_ret_track.sv
module lsu_ret_track #(
    parameter int LAT   = 11,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             push_load_i,
    input  logic             push_last_i,
    input  logic [IDX_W-1:0] push_idx_i,
    output logic             tail_valid_o,
    output logic             tail_load_o,
    output logic             tail_last_o,
    output logic [IDX_W-1:0] tail_idx_o
);

    logic             v_q    [LAT];
    logic             ld_q   [LAT];
    logic             last_q [LAT];
    logic [IDX_W-1:0] idx_q  [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[s] <= 1'b0; ld_q[s] <= 1'b0; last_q[s] <= 1'b0; idx_q[s] <= '0;
                end else begin
                    v_q[s]    <= push_i;
                    ld_q[s]   <= push_load_i;
                    last_q[s] <= push_last_i;
                    idx_q[s]  <= push_idx_i;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[s] <= 1'b0; ld_q[s] <= 1'b0; last_q[s] <= 1'b0; idx_q[s] <= '0;
                end else begin
                    v_q[s]    <= v_q[s-1];
                    ld_q[s]   <= ld_q[s-1];
                    last_q[s] <= last_q[s-1];
                    idx_q[s]  <= idx_q[s-1];
                end
            end
        end
    end

    assign tail_valid_o = v_q[LAT-1];
    assign tail_load_o  = v_q[LAT-1] && ld_q[LAT-1];
    assign tail_last_o  = v_q[LAT-1] && last_q[LAT-1];
    assign tail_idx_o   = idx_q[LAT-1];

    // Checker state: index expected at the tail next
    logic [IDX_W-1:0] exp_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            exp_q <= '0;
        else if (tail_last_o)  exp_q <= '0;
        else if (tail_valid_o) exp_q <= exp_q + IDX_W'(1);
    end

    // R6: completions leave the tracker in ascending element order
    p_ret_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid_o |-> (tail_idx_o == exp_q));

endmodule

// File: rtl/vec_stride_lsu.sv
module vec_stride_lsu #(
    parameter int NBANK    = 16,
    parameter int BANK_LAT = 11,
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 32,
    parameter int VLEN_MAX = 16,
    localparam int BANK_W  = $clog2(NBANK),
    localparam int IDX_W   = $clog2(VLEN_MAX),
    localparam int LEN_W   = $clog2(VLEN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              store_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [LEN_W-1:0]  vlen_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [IDX_W-1:0]  vr_ridx_o,
    input  logic [DATA_W-1:0] vr_rdata_i,
    output logic              vr_we_o,
    output logic [IDX_W-1:0]  vr_widx_o,
    output logic [DATA_W-1:0] vr_wdata_o
);
    import lsu_pkg::*;

    lsu_state_e state_q, state_d;
    logic       store_q;
    logic       done_q;

    logic              accept;
    logic              issue;
    logic              bank_free;
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_last;
    logic              tail_valid, tail_load, tail_last;
    logic [IDX_W-1:0]  tail_idx;

    assign accept = (state_q == ST_IDLE) && start_i && (vlen_i != '0);
    assign issue  = (state_q == ST_ISSUE) && bank_free;

    lsu_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_agen (
        .clk(clk), .rst_n(rst_n),
        .load_i(accept), .base_i(base_i), .stride_i(stride_i), .vlen_i(vlen_i),
        .step_i(issue),
        .addr_o(cur_addr), .idx_o(cur_idx), .last_o(cur_last)
    );

    lsu_bank_busy #(.NBANK(NBANK), .LAT(BANK_LAT)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .issue_i(issue), .bank_i(cur_addr[BANK_W-1:0]),
        .free_o(bank_free)
    );

    lsu_ret_track #(.LAT(BANK_LAT), .IDX_W(IDX_W)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .push_i(issue), .push_load_i(!store_q), .push_last_i(cur_last),
        .push_idx_i(cur_idx),
        .tail_valid_o(tail_valid), .tail_load_o(tail_load),
        .tail_last_o(tail_last), .tail_idx_o(tail_idx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)              state_d = ST_ISSUE;   // launch
            ST_ISSUE: if (issue && cur_last)   state_d = ST_DRAIN;   // last-issued
            ST_DRAIN: if (tail_last)           state_d = ST_IDLE;    // complete
            default:                           state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            store_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) store_q <= store_i;
            done_q  <= ((state_q == ST_IDLE) && start_i && (vlen_i == '0))
                    || ((state_q == ST_DRAIN) && tail_last);
        end
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        mem_req_o   = issue;
        mem_we_o    = issue && store_q;
        mem_addr_o  = cur_addr;
        mem_wdata_o = store_q ? vr_rdata_i : '0;
        vr_ridx_o   = cur_idx;
        vr_we_o     = tail_load;
        vr_widx_o   = tail_idx;
        vr_wdata_o  = mem_rdata_i;
    end

    // R6: load data arrives exactly when a load tag reaches the tail
    p_ret_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid_i == (tail_valid && tail_load));

    // R7: a store never writes the vector register
    p_store_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && store_q) |-> !vr_we_o);

    // R8: completion lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: no new request once the last element has issued
    p_drain_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !mem_req_o);

endmodule

// File: tb/sim_vec_stride_lsu.sv
`timescale 1ns/1ps
module sim_vec_stride_lsu;
    localparam int LAT = 11, NB = 16, AW = 24, DW = 32, VMAX = 16;
    localparam int LW = 5, IW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, start_i, store_i;
    logic [AW-1:0] base_i, stride_i;
    logic [LW-1:0] vlen_i;
    logic          busy_o, done_o, mem_req_o, mem_we_o, mem_rvalid_i, vr_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i, vr_rdata_i, vr_wdata_o;
    logic [IW-1:0] vr_ridx_o, vr_widx_o;

    vec_stride_lsu u0 (.*);

    function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction
    function automatic logic [DW-1:0] vr_val(logic [IW-1:0] i);
        return 32'hA500_0000 + 32'(i) * 32'd17;
    endfunction

    assign vr_rdata_i = vr_val(vr_ridx_o);

    // Memory model: fixed-latency return of load words
    logic          rv_p [LAT];
    logic [AW-1:0] ra_p [LAT];
    always @(posedge clk) begin
        rv_p[0] <= rst_n && mem_req_o && !mem_we_o;
        ra_p[0] <= mem_addr_o;
        for (int i = 1; i < LAT; i++) begin
            rv_p[i] <= rv_p[i-1];
            ra_p[i] <= ra_p[i-1];
        end
    end
    assign mem_rvalid_i = rv_p[LAT-1] === 1'b1;
    assign mem_rdata_i  = mem_rvalid_i ? mem_val(ra_p[LAT-1]) : '0;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int n_req, n_st, n_wb, ord_err, bank_err, exp_widx;
    int last_acc [NB];
    logic [DW-1:0] got [VMAX];
    logic [DW-1:0] st_mem [int];

    // Port monitor
    always @(negedge clk) if (rst_n) begin
        if (mem_req_o) begin
            n_req++;
            if (cyc + 1 - last_acc[mem_addr_o[3:0]] < LAT) bank_err++;
            last_acc[mem_addr_o[3:0]] = cyc + 1;
            if (mem_we_o) begin st_mem[int'(mem_addr_o)] = mem_wdata_o; n_st++; end
        end
        if (vr_we_o) begin
            if (int'(vr_widx_o) != exp_widx) ord_err++;
            got[vr_widx_o] = vr_wdata_o;
            exp_widx++; n_wb++;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_req = 0; n_st = 0; n_wb = 0; ord_err = 0; bank_err = 0; exp_widx = 0;
        for (int b = 0; b < NB; b++) last_acc[b] = -1000;
        for (int k = 0; k < VMAX; k++) got[k] = '0;
        st_mem.delete();
    endtask

    task automatic launch(bit st, int base, int stride, int n);
        @(negedge clk);
        store_i = st; base_i = AW'(base); stride_i = AW'(stride); vlen_i = LW'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Called at the negedge after the start edge; returns cycles to done
    task automatic wait_done(input int s, output int lat);
        int guard = 0;
        while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
        lat = cyc - s;
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done width", done_o, 0);
    endtask

    task automatic chk_load(string req, int base, int stride, int n);
        int bad = 0;
        for (int k = 0; k < n; k++)
            if (got[k] !== mem_val(AW'(base + k * stride))) bad++;
        chk(bad == 0, req, "load data mismatches", bad, 0);
        chk(n_wb == n, "R6", "register writes", n_wb, n);
        chk(ord_err == 0, "R6", "write order errors", ord_err, 0);
        chk(bank_err == 0, "R3", "bank reuse violations", bank_err, 0);
    endtask

    task automatic t_reset();
        chk(busy_o == 0, "R11", "busy after reset", busy_o, 0);
        chk(done_o == 0, "R11", "done after reset", done_o, 0);
        chk(mem_req_o == 0, "R11", "req after reset", mem_req_o, 0);
    endtask

    task automatic t_unit_stride();
        int s, lat;
        clear_mon();
        launch(0, 24'h000100, 1, 16);
        s = cyc;
        chk(busy_o == 1, "R8", "busy after start", busy_o, 1);
        wait_done(s, lat);
        chk(lat == 16 + LAT, "R4", "stride 1 cycles", lat, 16 + LAT);
        chk_load("R1", 24'h000100, 1, 16);
        chk(busy_o == 0, "R8", "busy after done", busy_o, 0);
    endtask

    task automatic t_same_bank();
        int s, lat;
        clear_mon();
        launch(0, 24'h000203, 32, 4);
        s = cyc;
        wait_done(s, lat);
        chk(lat == 4 * LAT + 1, "R5", "stride 32 cycles", lat, 4 * LAT + 1);
        chk_load("R2", 24'h000203, 32, 4);
    endtask

    task automatic t_stride_two();
        int s, lat;
        clear_mon();
        launch(0, 5, 2, 16);
        s = cyc;
        wait_done(s, lat);
        // 8 banks reused: elements 0-7 at 1..8, 8-15 at 12..19, last return at 30
        chk(lat == 30, "R5", "stride 2 cycles", lat, 30);
        chk_load("R1", 5, 2, 16);
    endtask

    task automatic t_neg_stride();
        int s, lat;
        clear_mon();
        launch(0, 3, -1, 5);   // wraps below zero
        s = cyc;
        wait_done(s, lat);
        chk(lat == 5 + LAT, "R4", "stride -1 cycles", lat, 5 + LAT);
        chk_load("R1", 3, -1, 5);
    endtask

    task automatic t_store();
        int s, lat, bad = 0;
        clear_mon();
        launch(1, 100, 3, 8);
        s = cyc;
        wait_done(s, lat);
        chk(lat == 8 + LAT, "R8", "store completion cycles", lat, 8 + LAT);
        chk(n_st == 8, "R7", "store requests", n_st, 8);
        for (int k = 0; k < 8; k++)
            if (!st_mem.exists(100 + 3 * k) || st_mem[100 + 3 * k] !== vr_val(IW'(k))) bad++;
        chk(bad == 0, "R7", "stored word mismatches", bad, 0);
        chk(n_wb == 0, "R7", "register writes during store", n_wb, 0);
    endtask

    task automatic t_empty();
        int s, lat;
        clear_mon();
        launch(0, 0, 1, 0);
        s = cyc;
        wait_done(s, lat);
        chk(lat == 0, "R10", "zero count done delay", lat, 0);
        chk(n_req == 0, "R10", "requests for zero count", n_req, 0);
    endtask

    task automatic t_ignore_start();
        int s, lat;
        clear_mon();
        launch(0, 24'h000040, 16, 4);
        s = cyc;
        repeat (3) @(negedge clk);
        store_i = 1'b1; base_i = 24'h000900; stride_i = 24'd1; vlen_i = LW'(2);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(s, lat);
        chk(lat == 4 * LAT + 1, "R9", "cycles with stray start", lat, 4 * LAT + 1);
        chk(n_st == 0, "R9", "store requests from stray start", n_st, 0);
        chk(n_req == 4, "R9", "total requests", n_req, 4);
        chk_load("R9", 24'h000040, 16, 4);
    endtask

    always @(posedge clk) if (cyc == 20000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; store_i = 1'b0;
        base_i = '0; stride_i = '0; vlen_i = '0;
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unit_stride();
        t_same_bank();
        t_stride_two();
        t_neg_stride();
        t_store();
        t_empty();
        t_ignore_start();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule